// File: doc/BRIEF.md
# Debug-to-CPU Register Access Bridge

This block carries one 32-bit register access at a time from a debug shift-clock domain into a special-register bus that runs on the CPU clock. A caller on the debug clock presents an address, a direction flag and write data together with a one-cycle strobe. The block captures all three at once and flips a request toggle. That toggle is synchronised into the CPU clock, where the block runs a strobe/acknowledge handshake. Completion returns through a second toggle. The caller polls a ready flag as a status bit. Ready falls on the edge after a request is taken and rises again once the access has finished. The bus has no error response, so an access ends only when the CPU side acknowledges it.

Addresses are word addresses and the bridge passes them through unchanged; the caller steps them by one between accesses. Data from a read is held in a CPU-side register from the acknowledge onward. It is copied into the debug-side output when completion arrives, so the value the caller reads never moves while ready is high.

Top module: `dbg_cpu_reg_bridge`

## Requirements
- R1: On a debug-clock rising edge where `req_stb` is high and `rsp_ready` is high, `req_addr`, `req_read` and `req_wdata` are captured together, and exactly these values appear on `bus_addr` and `bus_wdata` for the whole resulting bus access.
- R2: `req_read` = 1 requests a read and drives `bus_we` = 0; `req_read` = 0 requests a write and drives `bus_we` = 1.
- R3: `rsp_ready` goes low on the debug-clock edge that accepts a request and stays low until that request has completed.
- R4: `bus_stb` stays high until a CPU-clock edge where `bus_ack` is high, and is low from the following cycle. `bus_ack` while `bus_stb` is low has no effect.
- R5: For a read, `bus_rdata` is captured on the acknowledging edge, and that value appears on `rsp_rdata` when `rsp_ready` rises. `rsp_rdata` does not change while `rsp_ready` stays high.
- R6: A strobe while `rsp_ready` is low is ignored: it starts no bus access and does not change the fields of the access in flight.
- R7: After reset, `rsp_ready` is 1, and `bus_stb`, `bus_we`, `bus_addr`, `bus_wdata` and `rsp_rdata` are all 0.
- R8: `bus_stb` rises on the third CPU-clock rising edge after the accepting debug edge. `rsp_ready` rises on the third debug-clock rising edge after the acknowledging CPU edge.
- R9: A completed write leaves `rsp_rdata` at the value of the last completed read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| dclk | input | 1 | Debug shift clock |
| cclk | input | 1 | CPU clock |
| rst | input | 1 | Active-high reset, held over edges of both clocks |
| req_stb | input | 1 | One-cycle request strobe, debug clock |
| req_read | input | 1 | 1 = read, 0 = write |
| req_addr | input | ADDR_W | Word address of the access |
| req_wdata | input | DATA_W | Write data |
| rsp_rdata | output | DATA_W | Data of the last completed read |
| rsp_ready | output | 1 | High when no access is pending |
| bus_addr | output | ADDR_W | CPU bus address |
| bus_wdata | output | DATA_W | CPU bus write data |
| bus_rdata | input | DATA_W | CPU bus read data |
| bus_stb | output | 1 | CPU bus strobe |
| bus_we | output | 1 | CPU bus write enable |
| bus_ack | input | 1 | CPU bus acknowledge |

## Verification
The bus strobe is due three CPU-clock edges after the debug edge that takes the request. Ready is due three debug-clock edges after the acknowledging CPU edge, and the read data arrives with it. The bench runs the two clocks at periods and phases chosen so that their edges never coincide. This makes both latencies exact edge counts. A behavioural model counts the same edges from the stimulus it drives itself and compares ready, read data and every bus output at the falling edge of the clock that owns them. Strobes sent while the block is busy, and acknowledges with varying delays, exercise the ignore and hold rules inside these windows.

// File: rtl/dbg_bridge_pkg.sv
package dbg_bridge_pkg;
  typedef enum logic {
    BUS_IDLE   = 1'b0,
    BUS_ACTIVE = 1'b1
  } bus_state_e;

  // Write enable from the request direction flag (1 = read)
  function automatic logic write_from_dir(input logic is_read);
    return !is_read;
  endfunction
endpackage

// File: rtl/bridge_toggle_sync.sv
module bridge_toggle_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic tog_in,
  output logic pulse_out
);
  logic [STAGES-1:0] chain;
  logic              last_q;

  always_ff @(posedge clk) begin
    if (rst) chain[0] <= 1'b0;
    else     chain[0] <= tog_in;
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) chain[g] <= 1'b0;
      else     chain[g] <= chain[g-1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) last_q <= 1'b0;
    else     last_q <= chain[STAGES-1];
  end

  assign pulse_out = chain[STAGES-1] ^ last_q;
endmodule

// File: rtl/dbg_req_front.sv
module dbg_req_front #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              dclk,
  input  logic              rst,
  input  logic              req_stb,
  input  logic              req_read,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              done_pulse,
  input  logic [DATA_W-1:0] hold_rdata,
  output logic [ADDR_W-1:0] lat_addr,
  output logic [DATA_W-1:0] lat_wdata,
  output logic              lat_read,
  output logic              req_tog,
  output logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_rdata
);
  always_ff @(posedge dclk) begin
    if (rst) begin
      lat_addr  <= '0;
      lat_wdata <= '0;
      lat_read  <= 1'b0;
      req_tog   <= 1'b0;
      rsp_ready <= 1'b1;
      rsp_rdata <= '0;
    end else if (rsp_ready && req_stb) begin
      lat_addr  <= req_addr;
      lat_wdata <= req_wdata;
      lat_read  <= req_read;
      req_tog   <= ~req_tog;
      rsp_ready <= 1'b0;
    end else if (!rsp_ready && done_pulse) begin
      rsp_ready <= 1'b1;
      if (lat_read) rsp_rdata <= hold_rdata;
    end
  end

  // R3: accepted request pulls ready low
  a_r3_ready_drops: assert property (@(posedge dclk) disable iff (rst)
    (rsp_ready && req_stb) |=> !rsp_ready);

  // R6: strobe while busy leaves captured fields alone
  a_r6_busy_ignored: assert property (@(posedge dclk) disable iff (rst)
    (!rsp_ready && req_stb) |=> ($stable(lat_addr) && $stable(lat_wdata) && $stable(lat_read)));

  // R5: read data held while ready stays high
  a_r5_rdata_held: assert property (@(posedge dclk) disable iff (rst)
    (rsp_ready && $past(rsp_ready)) |-> $stable(rsp_rdata));
endmodule

// File: rtl/cpu_bus_engine.sv
module cpu_bus_engine
  import dbg_bridge_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              cclk,
  input  logic              rst,
  input  logic              req_pulse,
  input  logic [ADDR_W-1:0] lat_addr,
  input  logic [DATA_W-1:0] lat_wdata,
  input  logic              lat_read,
  input  logic              bus_ack,
  input  logic [DATA_W-1:0] bus_rdata,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  output logic              bus_stb,
  output logic              bus_we,
  output logic              done_tog,
  output logic [DATA_W-1:0] hold_rdata
);
  bus_state_e state;

  always_ff @(posedge cclk) begin
    if (rst) begin
      state      <= BUS_IDLE;
      bus_addr   <= '0;
      bus_wdata  <= '0;
      bus_stb    <= 1'b0;
      bus_we     <= 1'b0;
      done_tog   <= 1'b0;
      hold_rdata <= '0;
    end else begin
      case (state)
        BUS_IDLE: begin
          if (req_pulse) begin
            state     <= BUS_ACTIVE;
            bus_addr  <= lat_addr;
            bus_wdata <= lat_wdata;
            bus_we    <= write_from_dir(lat_read);
            bus_stb   <= 1'b1;
          end
        end
        BUS_ACTIVE: begin
          if (bus_ack) begin
            state    <= BUS_IDLE;
            bus_stb  <= 1'b0;
            done_tog <= ~done_tog;
            if (!bus_we) hold_rdata <= bus_rdata;
          end
        end
        default: state <= BUS_IDLE;
      endcase
    end
  end

  // R4: strobe held until acknowledge
  a_r4_stb_hold: assert property (@(posedge cclk) disable iff (rst)
    (bus_stb && !bus_ack) |=> bus_stb);

  // R4: strobe dropped the cycle after acknowledge
  a_r4_stb_drop: assert property (@(posedge cclk) disable iff (rst)
    (bus_stb && bus_ack) |=> !bus_stb);

  // R1: access fields stay put during an access
  a_r1_fields_stable: assert property (@(posedge cclk) disable iff (rst)
    (bus_stb && $past(bus_stb)) |-> ($stable(bus_addr) && $stable(bus_wdata) && $stable(bus_we)));
endmodule

// File: rtl/dbg_cpu_reg_bridge.sv
module dbg_cpu_reg_bridge #(
  parameter int ADDR_W      = 32,
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              dclk,
  input  logic              cclk,
  input  logic              rst,
  input  logic              req_stb,
  input  logic              req_read,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_ready,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] bus_rdata,
  output logic              bus_stb,
  output logic              bus_we,
  input  logic              bus_ack
);
  logic [ADDR_W-1:0] lat_addr;
  logic [DATA_W-1:0] lat_wdata;
  logic              lat_read;
  logic              req_tog, done_tog;
  logic              req_pulse, done_pulse;
  logic [DATA_W-1:0] hold_rdata;

  dbg_req_front #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) front_i (
    .dclk(dclk), .rst(rst), .req_stb(req_stb), .req_read(req_read),
    .req_addr(req_addr), .req_wdata(req_wdata), .done_pulse(done_pulse),
    .hold_rdata(hold_rdata), .lat_addr(lat_addr), .lat_wdata(lat_wdata),
    .lat_read(lat_read), .req_tog(req_tog), .rsp_ready(rsp_ready),
    .rsp_rdata(rsp_rdata)
  );

  bridge_toggle_sync #(.STAGES(SYNC_STAGES)) fwd_sync_i (
    .clk(cclk), .rst(rst), .tog_in(req_tog), .pulse_out(req_pulse)
  );

  cpu_bus_engine #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) engine_i (
    .cclk(cclk), .rst(rst), .req_pulse(req_pulse), .lat_addr(lat_addr),
    .lat_wdata(lat_wdata), .lat_read(lat_read), .bus_ack(bus_ack),
    .bus_rdata(bus_rdata), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_stb(bus_stb), .bus_we(bus_we), .done_tog(done_tog),
    .hold_rdata(hold_rdata)
  );

  bridge_toggle_sync #(.STAGES(SYNC_STAGES)) back_sync_i (
    .clk(dclk), .rst(rst), .tog_in(done_tog), .pulse_out(done_pulse)
  );
endmodule

// File: tb/dbg_cpu_reg_bridge_tb_top.sv
`timescale 1ns/100ps
module dbg_cpu_reg_bridge_tb_top;
  logic        dclk = 1'b0, cclk = 1'b0, rst = 1'b1;
  logic        req_stb = 1'b0, req_read = 1'b0;
  logic [31:0] req_addr = '0, req_wdata = '0;
  logic [31:0] rsp_rdata, bus_addr, bus_wdata;
  logic [31:0] bus_rdata = '0;
  logic        rsp_ready, bus_stb, bus_we;
  logic        bus_ack = 1'b0;

  int n_checks = 0, n_fail = 0;
  bit run = 0;
  bit done = 0;

  // model state
  bit          m_ready = 1, m_stb = 0, m_fwd = 0, m_back = 0, m_rd = 0;
  int          m_ccnt = 0, m_dcnt = 0;
  logic [31:0] m_addr = '0, m_wdata = '0, m_hold = '0, m_rdata = '0;

  int resp_wait = 0, wcnt = 0, rseed = 0;

  always #2.5 dclk = ~dclk;
  initial begin
    #1.3 cclk = 1'b1;
    forever #3.5 cclk = ~cclk;
  end

  dbg_cpu_reg_bridge dut_i (
    .dclk(dclk), .cclk(cclk), .rst(rst), .req_stb(req_stb), .req_read(req_read),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_rdata(rsp_rdata),
    .rsp_ready(rsp_ready), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_stb(bus_stb), .bus_we(bus_we), .bus_ack(bus_ack)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // model: debug clock
  always @(posedge dclk) begin
    if (run) begin
      if (m_back) begin
        m_dcnt++;
        if (m_dcnt == 3) begin
          m_ready = 1; m_back = 0;
          if (m_rd) m_rdata = m_hold;
        end
      end else if (m_ready && req_stb) begin
        m_ready = 0; m_fwd = 1; m_ccnt = 0;
        m_addr = req_addr; m_wdata = req_wdata; m_rd = req_read;
      end
    end
  end

  // model: CPU clock
  always @(posedge cclk) begin
    if (run) begin
      if (m_fwd) begin
        m_ccnt++;
        if (m_ccnt == 3) begin m_stb = 1; m_fwd = 0; end
      end else if (m_stb && bus_ack) begin
        m_stb = 0; m_back = 1; m_dcnt = 0;
        if (m_rd) m_hold = bus_rdata;
      end
    end
  end

  // responder on the CPU bus, driven at falling edges
  always @(negedge cclk) begin
    rseed = rseed * 1103515245 + 12345;
    if (bus_ack) begin
      bus_ack = 1'b0;
      bus_rdata = rseed;
    end else if (bus_stb && run) begin
      if (wcnt >= resp_wait) begin
        bus_ack = 1'b1;
        bus_rdata = 32'hC0DE_0000 ^ rseed;
        wcnt = 0;
      end else begin
        wcnt++;
        bus_rdata = rseed;
      end
    end else begin
      bus_rdata = rseed;
      // R4: stray acknowledge with no strobe must do nothing
      if (run && !bus_stb && (rseed[7:0] == 8'h11)) bus_ack = 1'b1;
    end
  end

  // compare on every debug clock
  always @(negedge dclk) begin
    if (run && !done) begin
      check(rsp_ready == m_ready, "R3 R8 ready", {31'd0, rsp_ready}, {31'd0, m_ready});
      if (m_ready)
        check(rsp_rdata == m_rdata, "R5 R9 rdata", rsp_rdata, m_rdata);
    end
  end

  // compare on every CPU clock
  always @(negedge cclk) begin
    if (run && !done) begin
      check(bus_stb == m_stb, "R4 R6 R8 strobe", {31'd0, bus_stb}, {31'd0, m_stb});
      if (m_stb) begin
        check(bus_addr == m_addr, "R1 addr", bus_addr, m_addr);
        check(bus_we == !m_rd, "R2 direction", {31'd0, bus_we}, {31'd0, !m_rd});
        if (!m_rd) check(bus_wdata == m_wdata, "R1 wdata", bus_wdata, m_wdata);
      end
    end
  end

  task automatic access(input bit rd, input logic [31:0] a, input logic [31:0] d,
                        input int wt, input bit poke);
    @(negedge dclk);
    while (!rsp_ready) @(negedge dclk);
    resp_wait = wt;
    req_stb = 1'b1; req_read = rd; req_addr = a; req_wdata = d;
    @(negedge dclk);
    req_stb = 1'b0;
    if (poke) begin
      // R6: strobes while busy with other fields
      repeat (2) begin
        @(negedge dclk);
        req_stb = 1'b1; req_read = ~rd; req_addr = ~a; req_wdata = ~d;
        @(negedge dclk);
        req_stb = 1'b0;
      end
    end
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge dclk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (6) @(posedge dclk);
    @(negedge dclk);
    // R7: reset state
    check(rsp_ready == 1'b1, "R7 ready", {31'd0, rsp_ready}, 32'd1);
    check(bus_stb == 1'b0, "R7 stb", {31'd0, bus_stb}, 32'd0);
    check(bus_we == 1'b0, "R7 we", {31'd0, bus_we}, 32'd0);
    check(bus_addr == '0, "R7 addr", bus_addr, 32'd0);
    check(bus_wdata == '0, "R7 wdata", bus_wdata, 32'd0);
    check(rsp_rdata == '0, "R7 rdata", rsp_rdata, 32'd0);
    rst = 1'b0;
    run = 1;
    repeat (3) @(negedge dclk);

    access(1'b0, 32'h0000_0010, 32'hDEAD_BEEF, 0, 0);  // R1 R2 write
    access(1'b1, 32'h0000_0011, 32'h0,         0, 0);  // R5 read
    access(1'b1, 32'h0000_0012, 32'h0,         5, 0);  // R4 long wait
    access(1'b0, 32'h0000_0013, 32'h1234_5678, 3, 1);  // R6 pokes, R9
    access(1'b1, 32'hFFFF_FFFF, 32'h0,         1, 1);  // R6 read with pokes
    access(1'b0, 32'h0000_0000, 32'hFFFF_FFFF, 7, 0);  // R9 write after read
    for (int i = 0; i < 8; i++)
      access(i[0], 32'h100 + i, 32'hA000_0000 + i, i % 4, i[1]);
    @(negedge dclk);
    while (!rsp_ready) @(negedge dclk);
    repeat (10) @(negedge dclk);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule